// File: doc/BRIEF.md
# SD Command Response Checker

This block sits behind the command transmitter of an SD host and takes over once a command has gone out. A one-cycle `start` strobe latches the issued command index, a two-bit response kind and the check settings. The block then watches the card's command line, one sample per `bit_en` pulse. It hunts for the start bit and shifts in the response. At the end bit it judges the response, and it raises a one-cycle `done` when the exchange is over. When the response kind has a busy phase, `done` waits until the card releases busy. The whole response is presented on `rsp_data`.

The block makes three checks. A CRC7 check is applied when `crc_chk_en` is set. An index compare is applied when `idx_chk_en` is set. An end-bit check is always applied. An automatically issued stop command (`auto_stop`) turns on both the CRC and index checks whatever the enables say. The three error flags stay set until the control logic writes ones to the matching bits of `err_clr`.

The control is a four-state machine:
- `ST_IDLE`: waits for `start`.
- `ST_HUNT`: waits for a 0 on the idle-high line.
- `ST_RECV`: counts the response bits down to bit 0.
- `ST_BUSY`: waits for the card to release busy.

The transitions are:
- start-with-response: `ST_IDLE` to `ST_HUNT`
- start-bit-seen: `ST_HUNT` to `ST_RECV`
- end-bit-no-busy: `ST_RECV` to `ST_IDLE`
- end-bit-with-busy: `ST_RECV` to `ST_BUSY`
- busy-released: `ST_BUSY` to `ST_IDLE`

A start with response kind 0 stays in `ST_IDLE` and only pulses `done`.

Top module: `sd_rsp_checker`

## Requirements
- R1: With `rsp_kind`=0 (no response), a `start` accepted in idle gives `done`=1 in the cycle after the start edge, with no check made, `busy_wait` staying 0 and no flag changing.
- R2: With `rsp_kind`=2 (48 bits), the first `bit_en` sample of 0 after `start` is response bit 47. The next 47 samples are bits 46..0. `done` rises on the edge that samples bit 0, and `rsp_data` then holds the response in bits 47:0 with zeros above.
- R3: With `rsp_kind`=1 (136 bits), the response is 136 samples long and `rsp_data`[135:0] holds it at the edge that samples bit 0, where `done` rises. No index check is made for this kind.
- R4: With `rsp_kind`=3 (48 bits then busy), the edge that samples the end bit sets `busy_wait`=1 and not `done`. `busy_wait` stays high until a `bit_en` sample finds `busy_in`=0. On that edge `done` pulses and `busy_wait` falls.
- R5: CRC7 uses x^7+x^3+1, shifts MSB first and starts from zero. It covers bits 47..8 of a 48-bit response, or bits 127..8 of a 136-bit one, and is compared with bits 7:1. A mismatch sets `crc_err` when `crc_chk_en` or `auto_stop` was set at `start`.
- R6: In 48-bit kinds, response bits 45:40 are compared with `issued_idx`. A mismatch sets `idx_err` when `idx_chk_en` or `auto_stop` was set at `start`.
- R7: With `crc_chk_en`, `idx_chk_en` and `auto_stop` all 0, a corrupted CRC or a wrong index sets neither `crc_err` nor `idx_err`.
- R8: A sampled end bit (bit 0) of 0 sets `end_err` in every response kind.
- R9: The flags are 0 after reset and stay set until cleared by `err_clr` (bit 0 `crc_err`, bit 1 `idx_err`, bit 2 `end_err`). A clear does its work one edge after it is driven. An error detected on the same edge as a clear leaves the flag set.
- R10: A `start` arriving while the block is not idle is ignored: it gives no `done` and does not restart the exchange.
- R11: `done` is a single-cycle pulse and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe: a command has been issued |
| rsp_kind | input | 2 | Response kind: 0 none, 1 136-bit, 2 48-bit, 3 48-bit then busy |
| issued_idx | input | 6 | Index of the issued command |
| idx_chk_en | input | 1 | Enable the index compare |
| crc_chk_en | input | 1 | Enable the CRC7 check |
| auto_stop | input | 1 | Automatic stop command: forces both checks on |
| bit_en | input | 1 | Sample strobe for `cmd_in` and `busy_in` |
| cmd_in | input | 1 | Command line level |
| busy_in | input | 1 | Card busy indication, 1 = busy |
| err_clr | input | 3 | Write-one-to-clear strobes for the flags |
| done | output | 1 | Exchange complete pulse |
| busy_wait | output | 1 | Waiting for the card to release busy |
| rsp_data | output | 136 | Captured response, right-justified |
| crc_err | output | 1 | Sticky CRC7 mismatch flag |
| idx_err | output | 1 | Sticky index mismatch flag |
| end_err | output | 1 | Sticky end-bit error flag |

## Verification
For kind 0, `done` is due one edge after the accepting `start`. For kinds 1 and 2, `done`, the flags and `rsp_data` all come from the single edge that samples the end bit. For kind 3, `busy_wait` is due on that same edge, and `done` on the edge that samples `busy_in` low. A flag clear takes effect one edge after `err_clr` is driven. The bench changes inputs on the falling edge and reads outputs on the following falling edge. Each result is therefore read exactly one rising edge after the sample that produces it, and `done` is read again one cycle later to confirm that it has fallen.

// File: rtl/sdrsp_pkg.sv
package sdrsp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_RECV = 2'd2,
        ST_BUSY = 2'd3
    } sdrsp_state_e;

    localparam logic [1:0] KIND_NONE       = 2'd0;
    localparam logic [1:0] KIND_LONG       = 2'd1;
    localparam logic [1:0] KIND_SHORT      = 2'd2;
    localparam logic [1:0] KIND_SHORT_BUSY = 2'd3;

endpackage

// File: rtl/sdrsp_crc7.sv
module sdrsp_crc7 #(
    parameter int          W    = 7,
    parameter logic [W-1:0] POLY = 7'h09
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic fb;
    assign fb = din ^ crc[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= '0;
        else if (clr)
            crc <= '0;
        else if (en)
            crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/sdrsp_shreg.sv
module sdrsp_shreg #(
    parameter int W = 135
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (en)
            q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/sd_rsp_checker.sv
module sd_rsp_checker
    import sdrsp_pkg::*;
#(
    parameter int LONG_BITS  = 136,
    parameter int SHORT_BITS = 48,
    parameter int IDX_W      = 6,
    parameter int IDX_LSB    = 40,
    parameter int CRC_W      = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           rsp_kind,
    input  logic [IDX_W-1:0]     issued_idx,
    input  logic                 idx_chk_en,
    input  logic                 crc_chk_en,
    input  logic                 auto_stop,
    input  logic                 bit_en,
    input  logic                 cmd_in,
    input  logic                 busy_in,
    input  logic [2:0]           err_clr,
    output logic                 done,
    output logic                 busy_wait,
    output logic [LONG_BITS-1:0] rsp_data,
    output logic                 crc_err,
    output logic                 idx_err,
    output logic                 end_err
);
    localparam int CNT_W = $clog2(LONG_BITS);
    localparam logic [CNT_W-1:0] LONG_TOP    = CNT_W'(LONG_BITS - 1);
    localparam logic [CNT_W-1:0] SHORT_TOP   = CNT_W'(SHORT_BITS - 1);
    localparam logic [CNT_W-1:0] LONG_CRC_HI = CNT_W'(LONG_BITS - 9);
    localparam logic [CNT_W-1:0] CRC_LO      = CNT_W'(CRC_W + 1);

    sdrsp_state_e         state_q, state_d;
    logic [CNT_W-1:0]     pos_q;
    logic [1:0]           kind_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 cchk_q, ichk_q;
    logic                 done_d;

    logic                 start_acc, last_bit, busy_rel, shift_en, crc_en;
    logic [CNT_W-1:0]     cur_top, crc_hi, in_pos;
    logic [CRC_W-1:0]     crc_calc;
    logic [LONG_BITS-2:0] sr_q;
    logic                 crc_bad, idx_bad;

    // ---------------- datapath helpers ----------------
    assign start_acc = start && (state_q == ST_IDLE);
    assign last_bit  = (state_q == ST_RECV) && bit_en && (pos_q == '0);
    assign busy_rel  = (state_q == ST_BUSY) && bit_en && !busy_in;
    assign cur_top   = (kind_q == KIND_LONG) ? LONG_TOP : SHORT_TOP;
    assign crc_hi    = (kind_q == KIND_LONG) ? LONG_CRC_HI : SHORT_TOP;
    assign in_pos    = (state_q == ST_HUNT) ? cur_top : pos_q;
    assign shift_en  = bit_en && (((state_q == ST_HUNT) && !cmd_in) || (state_q == ST_RECV));
    assign crc_en    = shift_en && (in_pos <= crc_hi) && (in_pos >= CRC_LO);
    assign crc_bad   = crc_calc != sr_q[CRC_W-1:0];
    assign idx_bad   = (kind_q != KIND_LONG) && (sr_q[IDX_LSB-1 +: IDX_W] != idx_q);

    sdrsp_crc7 #(.W(CRC_W), .POLY(CRC_W'(9))) crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_acc),
        .en    (crc_en),
        .din   (cmd_in),
        .crc   (crc_calc)
    );

    sdrsp_shreg #(.W(LONG_BITS - 1)) shreg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_acc),
        .en    (shift_en),
        .din   (cmd_in),
        .q     (sr_q)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_acc && (rsp_kind != KIND_NONE)) state_d = ST_HUNT;
            ST_HUNT: if (bit_en && !cmd_in)                    state_d = ST_RECV;
            ST_RECV: if (last_bit)
                         state_d = (kind_q == KIND_SHORT_BUSY) ? ST_BUSY : ST_IDLE;
            ST_BUSY: if (busy_rel)                             state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            kind_q  <= KIND_NONE;
            idx_q   <= '0;
            cchk_q  <= 1'b0;
            ichk_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_acc) begin
                kind_q <= rsp_kind;
                idx_q  <= issued_idx;
                cchk_q <= crc_chk_en | auto_stop;
                ichk_q <= idx_chk_en | auto_stop;
            end
            if ((state_q == ST_HUNT) && bit_en && !cmd_in)
                pos_q <= cur_top - 1'b1;
            else if ((state_q == ST_RECV) && bit_en)
                pos_q <= pos_q - 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        done_d    = (start_acc && (rsp_kind == KIND_NONE))
                  || (last_bit && (kind_q != KIND_SHORT_BUSY))
                  || busy_rel;
        busy_wait = (state_q == ST_BUSY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            rsp_data <= '0;
            crc_err  <= 1'b0;
            idx_err  <= 1'b0;
            end_err  <= 1'b0;
        end else begin
            done    <= done_d;
            crc_err <= (crc_err & ~err_clr[0]) | (last_bit && cchk_q && crc_bad);
            idx_err <= (idx_err & ~err_clr[1]) | (last_bit && ichk_q && idx_bad);
            end_err <= (end_err & ~err_clr[2]) | (last_bit && !cmd_in);
            if (last_bit)
                rsp_data <= {sr_q, cmd_in};
        end
    end
endmodule

// File: rtl/sdrsp_checker.sv
module sdrsp_checker
    import sdrsp_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   rsp_kind,
    input logic         bit_en,
    input logic         busy_in,
    input logic [2:0]   err_clr,
    input logic         done,
    input logic         busy_wait,
    input logic         crc_err,
    input logic         idx_err,
    input logic         end_err,
    input sdrsp_state_e state_q,
    input logic [1:0]   kind_q
);
    // R1
    no_rsp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && (state_q == ST_IDLE) && (rsp_kind == KIND_NONE) |=> done);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_wait && !(bit_en && !busy_in) |=> busy_wait && !done);

    // R4
    busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_wait && bit_en && !busy_in |=> done && !busy_wait);

    // R9
    crc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err && !err_clr[0] |=> crc_err);

    // R9
    idx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_err && !err_clr[1] |=> idx_err);

    // R9
    end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_err && !err_clr[2] |=> end_err);

    // R3
    long_no_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idx_err) |-> (kind_q != KIND_LONG));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && (state_q == ST_HUNT) |=> !done);
endmodule

bind sd_rsp_checker sdrsp_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rsp_kind  (rsp_kind),
    .bit_en    (bit_en),
    .busy_in   (busy_in),
    .err_clr   (err_clr),
    .done      (done),
    .busy_wait (busy_wait),
    .crc_err   (crc_err),
    .idx_err   (idx_err),
    .end_err   (end_err),
    .state_q   (state_q),
    .kind_q    (kind_q)
);

// File: tb/sd_rsp_checker_tb.sv
module sd_rsp_checker_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   rsp_kind = 2'd0;
    logic [5:0]   issued_idx = 6'd0;
    logic         idx_chk_en = 1'b0, crc_chk_en = 1'b0, auto_stop = 1'b0;
    logic         bit_en = 1'b0, cmd_in = 1'b1, busy_in = 1'b0;
    logic [2:0]   err_clr = 3'd0;
    logic         done, busy_wait, crc_err, idx_err, end_err;
    logic [135:0] rsp_data;

    int n_chk = 0, n_err = 0, cyc = 0;
    logic ex_crc = 1'b0, ex_idx = 1'b0, ex_end = 1'b0;

    always #10 clk = ~clk;

    sd_rsp_checker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rsp_kind(rsp_kind),
        .issued_idx(issued_idx), .idx_chk_en(idx_chk_en), .crc_chk_en(crc_chk_en),
        .auto_stop(auto_stop), .bit_en(bit_en), .cmd_in(cmd_in), .busy_in(busy_in),
        .err_clr(err_clr), .done(done), .busy_wait(busy_wait), .rsp_data(rsp_data),
        .crc_err(crc_err), .idx_err(idx_err), .end_err(end_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [135:0] act, input logic [135:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk({req, " crc_err"}, crc_err, ex_crc);
        chk({req, " idx_err"}, idx_err, ex_idx);
        chk({req, " end_err"}, end_err, ex_end);
    endtask

    function automatic logic [6:0] crc7_of(input logic [135:0] r, input int hi);
        logic [6:0] c = 7'd0;
        for (int i = hi; i >= 8; i--) begin
            logic fb = r[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [135:0] make_rsp(input logic [1:0] kind, input logic [5:0] idx,
                                              input bit bad_crc, input bit bad_end);
        logic [135:0] r = '0;
        int hi;
        if (kind == 2'd1) begin
            r[133:128] = 6'h3F;
            r[127:8]   = {$urandom, $urandom, $urandom, $urandom}[119:0];
            hi = 127;
        end else begin
            r[45:40] = idx;
            r[39:8]  = $urandom;
            hi = 47;
        end
        r[7:1] = crc7_of(r, hi);
        if (bad_crc) r[7:1] = r[7:1] ^ (7'd1 << ($urandom % 7));
        r[0] = !bad_end;
        return r;
    endfunction

    task automatic gap();
        repeat ($urandom % 3) @(negedge clk);
    endtask

    task automatic run_txn(input logic [1:0] kind, input logic [5:0] iss, input logic [5:0] ridx,
                           input bit cchk, input bit ichk, input bit aut,
                           input bit bad_crc, input bit bad_end,
                           input logic [2:0] clr_last, input bit poke);
        logic [135:0] r = make_rsp(kind, ridx, bad_crc, bad_end);
        int len = (kind == 2'd1) ? 136 : 48;
        bit s_crc = (cchk | aut) && bad_crc && (kind != 2'd0);
        bit s_idx = (ichk | aut) && kind[1] && (ridx != iss);
        bit s_end = bad_end && (kind != 2'd0);
        rsp_kind = kind; issued_idx = iss; crc_chk_en = cchk; idx_chk_en = ichk; auto_stop = aut;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (kind == 2'd0) begin
            chk("R1 done", done, 1'b1);
            chk("R1 busy_wait", busy_wait, 1'b0);
            chk_flags("R1");
            @(negedge clk);
            chk("R11 done falls", done, 1'b0);
            return;
        end
        chk("R11 no early done", done, 1'b0);
        repeat ($urandom % 4) begin
            cmd_in = 1'b1; bit_en = 1'b1; @(negedge clk); bit_en = 1'b0; gap();
        end
        for (int p = len - 1; p >= 0; p--) begin
            if (p == 0) err_clr = clr_last;
            cmd_in = r[p]; bit_en = 1'b1;
            @(negedge clk);
            bit_en = 1'b0; err_clr = 3'd0;
            if (p != 0) gap();
            if (poke && p == 30) begin
                start = 1'b1; rsp_kind = 2'd0;
                @(negedge clk);
                start = 1'b0; rsp_kind = kind;
                chk("R10 start ignored", done, 1'b0);
            end
        end
        cmd_in = 1'b1;
        ex_crc = (ex_crc & ~clr_last[0]) | s_crc;
        ex_idx = (ex_idx & ~clr_last[1]) | s_idx;
        ex_end = (ex_end & ~clr_last[2]) | s_end;
        if (kind != 2'd3) begin
            chk(kind == 2'd1 ? "R3 done" : "R2 done", done, 1'b1);
            chk(kind == 2'd1 ? "R3 rsp_data" : "R2 rsp_data", rsp_data, r);
            chk_flags("R5/R6/R8");
        end else begin
            chk("R4 busy_wait set", busy_wait, 1'b1);
            chk("R4 no done yet", done, 1'b0);
            chk("R2 rsp_data", rsp_data, r);
            chk_flags("R5/R6/R8");
            repeat (1 + $urandom % 3) begin
                busy_in = 1'b1; bit_en = 1'b1; @(negedge clk); bit_en = 1'b0;
                chk("R4 busy held", busy_wait, 1'b1);
                gap();
            end
            busy_in = 1'b0; bit_en = 1'b1; @(negedge clk); bit_en = 1'b0;
            chk("R4 done on release", done, 1'b1);
            chk("R4 busy_wait cleared", busy_wait, 1'b0);
        end
        @(negedge clk);
        chk("R11 done falls", done, 1'b0);
    endtask

    task automatic clear_flags(input logic [2:0] c);
        err_clr = c;
        @(negedge clk);
        err_clr = 3'd0;
        ex_crc &= ~c[0]; ex_idx &= ~c[1]; ex_end &= ~c[2];
        chk_flags("R9 clear");
    endtask

    initial begin
        void'($urandom(32'h5D3C_0A17));
        repeat (3) @(negedge clk);
        chk("R11 reset done", done, 1'b0);
        chk("R9 reset crc_err", crc_err, 1'b0);
        chk("R9 reset idx_err", idx_err, 1'b0);
        chk("R9 reset end_err", end_err, 1'b0);
        chk("R4 reset busy_wait", busy_wait, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: no response
        run_txn(2'd0, 6'd12, 6'd12, 1, 1, 0, 0, 0, 3'd0, 0);
        // R2: clean short, all checks on
        run_txn(2'd2, 6'd17, 6'd17, 1, 1, 0, 0, 0, 3'd0, 0);
        // R3: long, index check enabled but never applied
        run_txn(2'd1, 6'd2, 6'd9, 1, 1, 0, 0, 0, 3'd0, 0);
        // R7: corruption with checks off sets nothing
        run_txn(2'd2, 6'd5, 6'd6, 0, 0, 0, 1, 0, 3'd0, 0);
        chk("R7 crc_err stays 0", crc_err, 1'b0);
        chk("R7 idx_err stays 0", idx_err, 1'b0);
        // R5/R6: auto stop forces both checks on
        run_txn(2'd3, 6'd12, 6'd13, 0, 0, 1, 1, 0, 3'd0, 0);
        // R9: an error on the same edge as a clear wins
        run_txn(2'd2, 6'd8, 6'd8, 1, 0, 0, 1, 0, 3'd7, 0);
        clear_flags(3'd7);
        // R8: bad end bit, R10: start during reception
        run_txn(2'd2, 6'd3, 6'd3, 0, 0, 0, 0, 1, 3'd0, 1);
        clear_flags(3'd7);
        // R5: long CRC mismatch
        run_txn(2'd1, 6'd0, 6'd0, 1, 0, 0, 1, 0, 3'd0, 0);
        clear_flags(3'd1);

        for (int t = 0; t < 40; t++) begin
            logic [1:0] k  = 2'($urandom % 4);
            logic [5:0] is = 6'($urandom);
            logic [5:0] ri = ($urandom % 3 == 0) ? (is ^ 6'(1 + $urandom % 63)) : is;
            run_txn(k, is, ri, 1'($urandom), 1'($urandom), ($urandom % 5 == 0),
                    ($urandom % 3 == 0), ($urandom % 6 == 0), 3'd0, 0);
            if ($urandom % 2) clear_flags(3'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule